// File: doc/BRIEF.md
# Tapered-Group Carry-Skip Adder

This block adds two unsigned binary operands of a parameterized width together with a carry input. It returns the sum and a carry output. It is purely combinational. The operand bits are cut into consecutive ripple-carry groups, and each group carries a bypass multiplexer.

Each bit position is classed by its two operand bits:
- generate: both bits are 1;
- propagate: exactly one bit is 1;
- kill: both bits are 0.

A group whose bits all propagate cannot change the carry it receives. For such a group the bypass forwards the incoming carry straight to the next group, and the ripple inside the group is not on the path.

Group lengths come from one parameter vector, so the groups need not be of equal size. The default splits 60 bits as 4,5,6,7,8,8,7,6,5,4, from least to most significant. The groups are short at both ends and longer in the middle. This shape shortens the longest path: a carry starts at bit 0, ripples out of the first group, skips every middle group, and ripples into the last group.

Top module: `skip_adder_vg`

## Requirements
- R1: For every input, `{cout, sum}` equals the unsigned value of `a + b + cin`, with `cout` weighted 2^WIDTH.
- R2: Group lengths are taken from `GSIZES`, one 8-bit field per group, with field 0 holding the least significant group. The default for WIDTH = 60 is 4,5,6,7,8,8,7,6,5,4. A list whose total differs from WIDTH stops elaboration.
- R3: When every bit propagates (b = ~a), `sum` is all ones and `cout` is 0 for `cin` = 0. For `cin` = 1, `sum` is all zeros and `cout` is 1, as the carry passes every group bypass.
- R4: A generate at the most significant bit of a group makes that group's carry out 1, whatever carry enters the group. A kill at that bit makes the group's carry out 0. At the ports this shows in the lowest sum bit of the next group.
- R5: In the worst-case pattern, the carry generated at bit 0 propagates through bits 1 to WIDTH-2 and stops at the top bit. In that pattern the sum and `cout` still obey R1.
- R6: An alternating generate/kill pattern (a = b = 0x555...) gives `sum` = a shifted left by one plus `cin`, with `cout` = 0.
- R7: For every group, the carry chosen by the bypass multiplexer equals the carry the internal ripple chain produces.
- R8: The outputs depend only on the current inputs. There is no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the most significant group |

## Verification
On every evaluation, the embedded assertions check three things:
- the complete arithmetic result against the reference addition;
- the agreement between each group's bypass choice and its own ripple chain;
- the forced carry out when a group's top bit generates or kills.

That the bypass actually fires only shows through the bench's scenarios:
- all-propagate operands with both carry inputs;
- the bit-0 worst-case chain;
- the alternating generate/kill pattern;
- a generate placed on a group boundary, together with random vectors.

The bench also shows that the outputs follow the inputs with no clock.

// File: rtl/skip_adder_vg.sv
module skip_adder_vg #(
  parameter int WIDTH = 60,
  parameter int NGRP  = 10,
  parameter logic [NGRP*8-1:0] GSIZES =
    {8'd4, 8'd5, 8'd6, 8'd7, 8'd8, 8'd8, 8'd7, 8'd6, 8'd5, 8'd4}
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  function automatic int grp_off(int k);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += int'(GSIZES[8*j +: 8]);
    return acc;
  endfunction

  localparam int TOTAL = grp_off(NGRP);

  if (TOTAL != WIDTH) begin : gen_bad_list
    $error("skip_adder_vg: group sizes total %0d, width is %0d", TOTAL, WIDTH); // R2
  end

  logic [WIDTH-1:0] prop, gen;
  assign prop = a ^ b;
  assign gen  = a & b;

  for (genvar g = 0; g < NGRP; g++) begin : gen_grp
    localparam int OFF = grp_off(g);
    localparam int SZ  = int'(GSIZES[8*g +: 8]);

    logic          cin_l, cout_l, rip_out, gp;
    logic [SZ-1:0] s_loc;

    if (g == 0) begin : gen_first
      assign cin_l = cin;
    end else begin : gen_next
      assign cin_l = gen_grp[g-1].cout_l;
    end

    always_comb begin
      logic cc;
      cc = cin_l;
      for (int i = 0; i < SZ; i++) begin
        s_loc[i] = prop[OFF+i] ^ cc;
        cc = gen[OFF+i] | (prop[OFF+i] & cc);
      end
      rip_out = cc;
    end

    assign gp     = &prop[OFF +: SZ];
    assign cout_l = gp ? cin_l : rip_out;
    assign sum[OFF +: SZ] = s_loc;

    always_comb begin
      AST_BYPASS_AGREE: assert (cout_l == rip_out) else $error("bypass/ripple mismatch group %0d", g); // R7
      if (gen[OFF+SZ-1])
        AST_TOP_GEN: assert (cout_l) else $error("generate at group top lost, group %0d", g); // R4
      if (!gen[OFF+SZ-1] && !prop[OFF+SZ-1])
        AST_TOP_KILL: assert (!cout_l) else $error("kill at group top ignored, group %0d", g); // R4
    end
  end

  assign cout = gen_grp[NGRP-1].cout_l;

  always_comb begin
    AST_SUM_EXACT: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
      else $error("adder result wrong"); // R1
  end

endmodule

// File: tb/test_skip_adder_vg.sv
module test_skip_adder_vg;
  localparam int W = 60;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  skip_adder_vg i_skip_adder_vg (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  logic [W:0] exp_q[$];
  string      tag_q[$];
  int applied = 0, fails = 0;
  bit done = 1'b0;

  task automatic drive(input logic [W-1:0] xa, input logic [W-1:0] xb,
                       input logic xc, input string tag);
    @(posedge clk);
    a = xa; b = xb; cin = xc;
    exp_q.push_back({1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, xc});
    tag_q.push_back(tag);
    applied++;
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [W:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if ({cout, sum} !== e) begin
        fails++;
        $display("FAIL %s: got %h expected %h", t, {cout, sum}, e);
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] alt, pat;
    alt = '0;
    for (int i = 0; i < W; i += 2) alt[i] = 1'b1;
    pat = {2'b10, {29{2'b01}}};
    drive('0, '0, 1'b0, "R1 zero");
    drive('1, '1, 1'b1, "R1 max");
    drive(pat, ~pat, 1'b0, "R3 all-propagate cin0");
    drive(pat, ~pat, 1'b1, "R3 all-propagate cin1");
    drive('1, '0, 1'b1, "R3 all-propagate ones cin1");
    drive(alt, alt, 1'b0, "R6 alternating gen/kill");
    drive(alt, alt, 1'b1, "R6 alternating gen/kill cin1");
    drive({1'b0, {(W-2){1'b1}}, 1'b1}, {{(W-1){1'b0}}, 1'b1}, 1'b0, "R5 worst chain");
    drive({1'b1, {(W-2){1'b1}}, 1'b1}, {{(W-1){1'b0}}, 1'b1}, 1'b0, "R5 worst chain top prop");
    // bit 3 is top of group 0, bit 8 top of group 1, bit 59 top of last group
    drive(60'h8, 60'h8, 1'b0, "R4 generate at group0 top");
    drive(60'h7 | 60'h0, 60'h0, 1'b1, "R4 kill at group0 top");
    drive(60'h1F0 | 60'h100, 60'h100, 1'b0, "R2 group1 top bit 8 generate");
    drive({1'b1, 59'h0}, {1'b1, 59'h0}, 1'b1, "R2 last group top generate");
    drive(60'hFFF0, 60'h0010, 1'b0, "R2 carry across boundaries");
    for (int k = 0; k < 400; k++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      drive(ra[W-1:0], rb[W-1:0], 1'($urandom), "R1 random");
    end
    for (int k = 0; k < 20; k++) begin
      logic [63:0] ra;
      ra = {$urandom, $urandom};
      drive(ra[W-1:0], ~ra[W-1:0], 1'($urandom), "R8 propagate-heavy random");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule